// File: doc/BRIEF.md
# Counterphase Half-Rate Wide Accumulator

This block sums a stream of wide terms (100 bits by default) at a rate of one term per clock. The clock is shorter than the delay of one full-width addition, so the block does not run a single accumulator. It keeps two accumulator lanes and sends accepted terms to them in turn. A one-bit steering toggle picks the lane. Each accepted term is first copied into a hold register that belongs to its lane. Two edges later that lane adds the held term into its running total. Each lane's adder therefore has operands that stay fixed for two whole clock periods, so it can be treated as a two-cycle path. Because the steering alternates, at most one lane adds on any edge, and each lane's enable runs at half rate and in opposite phase to the other lane's enable.

A read strobe combines the two lanes into one total. This also takes two cycles. On the first, the lower halves are added and the carry out is registered. On the second, the upper halves are added together with that registered carry. The total appears with a one-cycle valid pulse and then stays on the output until the next read or a clear. The surrounding logic must hold off new terms just before and during the read edge, so that no lane update is still in flight. A synchronous clear empties both lanes and the read path. The total wraps modulo 2^W.

Top module: `halfrate_accum`

## Requirements
- R1: When `clear` is sampled high, both lane totals, the steering toggle, `total` and `total_valid` become zero at that edge, and no read in flight completes.
- R2: A read whose strobe is sampled at edge k returns, in `total`, the sum modulo 2^W of every term accepted since the last clear. Terms must not be accepted at edges k-2, k-1 and k.
- R3: `total_valid` is a one-cycle pulse. It goes high at edge k+2 for a strobe sampled at edge k and is low at every other time.
- R4: `total` changes only at an edge that raises `total_valid` or at a clear, and holds its value otherwise.
- R5: Terms are accepted on every edge where `term_valid` is high, including long back-to-back runs, with no stall.
- R6: Overflow wraps: the total is taken modulo 2^W, so three all-ones terms read back as all-ones minus two.
- R7: `term` is ignored on any edge where `term_valid` is low, whatever its value.
- R8: Accepted terms go to lane 0 when the toggle is 0 and to lane 1 when it is 1. The toggle flips only on accepted terms. A lane total changes only at the edge two after its term was captured, and at most one lane changes per edge.
- R9: The carry out of the lower half (bits L-1..0, L = W/2) of the lane sum is carried into the upper half of `total`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clear | input | 1 | Synchronous clear of all state, active high |
| term_valid | input | 1 | Marks `term` as a term to accumulate this cycle |
| term | input | W | Term to add |
| read_req | input | 1 | Strobe asking for the combined total |
| total | output | W | Sum of both lanes, held between reads |
| total_valid | output | 1 | One-cycle pulse when a new `total` is presented |

## Verification
The assertions on read latency and output hold assume that no term is accepted at the read edge or at the two edges before it. Under that condition the lanes are quiet for the whole two-cycle combine. The bench meets it by always sending two idle cycles and then the strobe with `term_valid` low. It is free to place terms at any other edge, including the edge directly after a strobe, where the combine is still running. The toggle and lane-enable properties make no assumption about the inputs. The random stretches drive garbage on `term` whenever `term_valid` is low.

// File: rtl/halfrate_accum.sv
module halfrate_accum #(
  parameter int W = 100,
  localparam int L = W / 2,
  localparam int H = W - L
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         term_valid,
  input  logic [W-1:0] term,
  input  logic         read_req,
  output logic [W-1:0] total,
  output logic         total_valid
);

  logic                steer;
  logic [1:0]          take;
  logic [1:0][W-1:0]   lane_sum;
  logic [1:0][W-1:0]   held;
  logic [1:0]          win0;
  logic [1:0]          lane_en;
  logic [1:0]          rd_pipe;
  logic [L:0]          low_q;
  logic [L:0]          low_next;
  logic [H-1:0]        high_next;

  assign take[0] = term_valid & ~steer;
  assign take[1] = term_valid &  steer;

  assign low_next  = {1'b0, lane_sum[0][L-1:0]} + {1'b0, lane_sum[1][L-1:0]};
  assign high_next = lane_sum[0][W-1:L] + lane_sum[1][W-1:L] + {{(H-1){1'b0}}, low_q[L]};

  always_ff @(posedge clk) begin
    if (clear) begin
      steer    <= 1'b0;
      lane_sum <= '0;
      held     <= '0;
      win0     <= '0;
      lane_en  <= '0;
    end else begin
      if (term_valid) steer <= ~steer;
      for (int i = 0; i < 2; i++) begin
        if (take[i])    held[i]     <= term;
        if (lane_en[i]) lane_sum[i] <= lane_sum[i] + held[i];
      end
      win0    <= take;
      lane_en <= win0;
    end
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      rd_pipe     <= '0;
      low_q       <= '0;
      total       <= '0;
      total_valid <= 1'b0;
    end else begin
      rd_pipe     <= {rd_pipe[0], read_req};
      if (rd_pipe[0]) low_q <= low_next;
      if (rd_pipe[1]) total <= {high_next, low_q[L-1:0]};
      total_valid <= rd_pipe[1];
    end
  end

endmodule

// File: rtl/halfrate_accum_props.sv
module halfrate_accum_props #(
  parameter int W = 100
) (
  input logic              clk,
  input logic              clear,
  input logic              term_valid,
  input logic              read_req,
  input logic [W-1:0]      total,
  input logic              total_valid,
  input logic              steer,
  input logic [1:0]        lane_en,
  input logic [1:0][W-1:0] lane_sum
);

  assert_single_lane_R8: assert property (@(posedge clk) disable iff (clear)
    $onehot0(lane_en));

  assert_lane0_idle_R8: assert property (@(posedge clk) disable iff (clear)
    !lane_en[0] |=> $stable(lane_sum[0]));

  assert_lane1_idle_R8: assert property (@(posedge clk) disable iff (clear)
    !lane_en[1] |=> $stable(lane_sum[1]));

  assert_steer_flip_R8: assert property (@(posedge clk) disable iff (clear)
    term_valid |=> steer != $past(steer));

  assert_steer_keep_R8: assert property (@(posedge clk) disable iff (clear)
    !term_valid |=> $stable(steer));

  assert_valid_cause_R3: assert property (@(posedge clk) disable iff (clear)
    total_valid |-> $past(read_req, 3));

  assert_valid_due_R3: assert property (@(posedge clk) disable iff (clear)
    ($past(read_req, 3) && !$past(clear, 3) && !$past(clear, 2) && !$past(clear, 1))
      |-> total_valid);

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (clear)
    (total_valid && !$past(read_req, 2)) |=> !total_valid);

  assert_cleared_R1: assert property (@(posedge clk) disable iff (clear)
    $past(clear) |-> (!total_valid && total == '0));

  assert_total_hold_R4: assert property (@(posedge clk) disable iff (clear)
    !$stable(total) |-> (total_valid || $past(clear)));

endmodule

bind halfrate_accum halfrate_accum_props #(.W(W)) u_props (
  .clk(clk),
  .clear(clear),
  .term_valid(term_valid),
  .read_req(read_req),
  .total(total),
  .total_valid(total_valid),
  .steer(steer),
  .lane_en(lane_en),
  .lane_sum(lane_sum)
);

// File: tb/sim_halfrate_accum.sv
module sim_halfrate_accum;
  localparam int W = 100;
  localparam int L = W / 2;

  logic         clk = 1'b0;
  logic         clear = 1'b1;
  logic         term_valid = 1'b0;
  logic [W-1:0] term = '0;
  logic         read_req = 1'b0;
  logic [W-1:0] total;
  logic         total_valid;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] m_sum = '0;
  logic         s1_v = 1'b0, s2_v = 1'b0, o_v = 1'b0;
  logic [W-1:0] s1_val = '0, s2_val = '0, o_val = '0;

  always #10 clk = ~clk;

  halfrate_accum #(.W(W)) u0 (
    .clk(clk), .clear(clear), .term_valid(term_valid), .term(term),
    .read_req(read_req), .total(total), .total_valid(total_valid)
  );

  function automatic logic [W-1:0] rnd();
    logic [127:0] t;
    t = {$urandom(), $urandom(), $urandom(), $urandom()};
    return t[W-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit c, input bit v, input logic [W-1:0] d, input bit r);
    clear = c; term_valid = v; term = d; read_req = r;
    @(posedge clk);
    if (c) begin
      m_sum = '0; s1_v = 0; s2_v = 0; o_v = 0;
      s1_val = '0; s2_val = '0; o_val = '0;
    end else begin
      o_v = s2_v;
      if (s2_v) o_val = s2_val;
      s2_v = s1_v; s2_val = s1_val;
      s1_v = r; s1_val = m_sum;
      if (v) m_sum = m_sum + d;
    end
    @(negedge clk);
    chk(total_valid == o_v, "R3 valid pulse", {{(W-1){1'b0}}, total_valid}, {{(W-1){1'b0}}, o_v});
    chk(total == o_val, o_v ? "R2 read total" : "R4 held total", total, o_val);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, rnd(), 1'b0);
  endtask

  task automatic feed(input logic [W-1:0] d);
    cyc(1'b0, 1'b1, d, 1'b0);
  endtask

  task automatic do_read(input string tag, input logic [W-1:0] exp);
    idle(); idle();
    cyc(1'b0, 1'b0, rnd(), 1'b1);
    idle(); idle();
    chk(total_valid == 1'b1, tag, {{(W-1){1'b0}}, total_valid}, {{(W-1){1'b0}}, 1'b1});
    chk(total == exp, tag, total, exp);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] acc;
    @(negedge clk);
    cyc(1'b1, 1'b0, '0, 1'b0);
    cyc(1'b1, 1'b0, '0, 1'b0);
    chk(total == '0 && !total_valid, "R1 reset state", total, '0);

    feed(100'd5);
    do_read("R2 single term", 100'd5);

    cyc(1'b1, 1'b0, '0, 1'b0);
    acc = '0;
    for (int i = 1; i <= 12; i++) begin
      feed(W'(i));
      acc = acc + W'(i);
    end
    do_read("R5 back-to-back run", acc);

    cyc(1'b1, 1'b0, '0, 1'b0);
    feed(100'd5);
    cyc(1'b0, 1'b0, '1, 1'b0);
    cyc(1'b0, 1'b0, '1, 1'b0);
    do_read("R7 invalid terms ignored", 100'd5);

    cyc(1'b1, 1'b0, '0, 1'b0);
    feed(100'd3); idle(); idle(); feed(100'd10); feed(100'd20); idle(); feed(100'd40);
    do_read("R8 alternation across gaps", 100'd73);

    cyc(1'b1, 1'b0, '0, 1'b0);
    feed('1); feed('1); feed('1);
    do_read("R6 wrap modulo 2^W", '1 - 100'd2);

    cyc(1'b1, 1'b0, '0, 1'b0);
    feed({{(W-L){1'b0}}, {L{1'b1}}});
    feed({{(W-L){1'b0}}, {L{1'b1}}});
    acc = ({{(W-L){1'b0}}, {L{1'b1}}}) << 1;
    do_read("R9 low-half carry", acc);

    feed(100'd9); feed(100'd9);
    cyc(1'b1, 1'b0, '0, 1'b0);
    chk(total == '0 && !total_valid, "R1 clear mid-stream", total, '0);
    feed(100'd7);
    do_read("R1 only terms after clear", 100'd7);

    idle(); idle();
    cyc(1'b0, 1'b0, rnd(), 1'b1);
    feed(100'd4);
    cyc(1'b1, 1'b0, '0, 1'b0);
    chk(!total_valid, "R1 read in flight dropped", {{(W-1){1'b0}}, total_valid}, '0);
    idle(); idle();

    for (int blk = 0; blk < 60; blk++) begin
      int n;
      n = $urandom_range(0, 9);
      for (int j = 0; j < n; j++)
        cyc(1'b0, 1'($urandom_range(0, 1)), rnd(), 1'b0);
      do_read("R2 random stream", m_sum);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule